// File: doc/BRIEF.md
# Triple-Redundant Byte Store Controller

This controller keeps a single logical byte in a byte-wide nonvolatile memory. It holds three copies of the byte in a group of three consecutive addresses. The first address of the active group is itself a byte stored at memory address 0. Every host operation reads that pointer first. A write then stores the byte three times in ascending order. Each copy is read back right after it is written, and a copy that reads back wrong is remembered as suspect.

A host read fetches the three copies and combines them by majority vote. It reports either a clean result, a single-copy mismatch or a total disagreement. On a total disagreement the controller moves to the next free group three addresses further on. It rewrites the pointer and then writes the recovered value (copy 0) into the new group. When no further group fits in the memory, a sticky exhausted flag is raised and nothing is relocated.

The host side is a pulse-request, pulse-acknowledge port. The memory side issues one strobe at a time and honours a busy signal from the memory device.

Top module: `tmr_byte_store`

## Requirements
- R1: Every host operation begins with a read of memory address 0. The value read (low ADDR_W bits) is the base of the active group, and the copies live at base, base+1 and base+2.
- R2: A host write stores the byte at base, base+1 and base+2 in that order. Each copy write is immediately followed by a read of the same address, so a write produces exactly 7 memory accesses.
- R3: If all three copies read equal (and none is suspect), a host read returns that value with both mismatch flags low.
- R4: If exactly two copies agree, a host read returns their value with host_single high and host_total low.
- R5: If no two copies agree, a host read returns copy 0 with host_total high and host_single low. The two flags are never high together.
- R6: On a total disagreement with room left, address 0 is rewritten to base+3 before the three copies are written at the new group with the copy-0 value. A pointer write only happens in this situation.
- R7: Room exists only if base+5 is no more than MEM_DEPTH-1. When there is no room, host_exhausted rises and stays high until reset, and the read issues no memory write.
- R8: A copy whose read-back after writing differed from the written byte is counted as disagreeing on the next host read, even if its stored value now matches.
- R9: host_ack is a one-cycle pulse at the end of every sequence. Requests arriving while a sequence runs are ignored. When read and write are requested together, the write wins.
- R10: mem_we and mem_rd are never high together, and neither is raised while mem_busy is high.
- R11: After reset, host_ack, host_single, host_total, host_exhausted, mem_we and mem_rd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_rd | input | 1 | Read request pulse |
| host_wr | input | 1 | Write request pulse |
| host_wdata | input | 8 | Byte to store on a write |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Voted byte of the last read |
| host_single | output | 1 | Last read saw exactly one outlier copy |
| host_total | output | 1 | Last read saw three different copies |
| host_exhausted | output | 1 | Sticky: no group left for relocation |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid when busy is low after a read |
| mem_we | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_busy | input | 1 | Memory busy; no strobe is accepted while high |

## Verification
All host-visible results (voted byte, flags, exhausted flag and memory contents) become due in the cycle where host_ack is high. The number of cycles before that point depends on memory latency, so the bench watches falling clock edges until it sees the acknowledge, samples every output on that same edge, and checks on the next falling edge that the acknowledge has gone. The memory model logs every strobe, and this log is checked after the acknowledge, when no access can still be in flight. That is how the order and count of accesses (R1, R2, R6, R7) are verified. Checks that a request is ignored run over a quiet window of 20 cycles after the acknowledge, during which no strobe and no further acknowledge may appear.

// File: rtl/tmr_store_pkg.sv
package tmr_store_pkg;
   localparam int BYTE_W = 8;
   localparam int NCOPY  = 3;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_PTR, SQ_RD, SQ_VOTE, SQ_WR, SQ_RB, SQ_PWR, SQ_DONE
   } seq_t;

   typedef enum logic [1:0] {
      EN_IDLE, EN_ISSUE, EN_SETTLE, EN_WAIT
   } eng_t;

   typedef struct packed {
      logic [BYTE_W-1:0] value;
      logic              single;
      logic              total;
   } vote_t;
endpackage

// File: rtl/tmr_mem_engine.sv
module tmr_mem_engine
   import tmr_store_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              idle,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_rd,
   input  logic              mem_busy
);
   eng_t st;
   logic we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= EN_IDLE;
         we_q      <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         unique case (st)
            EN_IDLE: if (start) begin
               st        <= EN_ISSUE;
               we_q      <= op_we;
               mem_addr  <= addr;
               mem_wdata <= wdata;
            end
            EN_ISSUE:  if (!mem_busy) st <= EN_SETTLE;
            EN_SETTLE: st <= EN_WAIT;
            EN_WAIT:   if (!mem_busy) st <= EN_IDLE;
            default:   st <= EN_IDLE;
         endcase
      end
   end

   assign mem_we = (st == EN_ISSUE) && !mem_busy && we_q;
   assign mem_rd = (st == EN_ISSUE) && !mem_busy && !we_q;
   assign idle   = (st == EN_IDLE);
   assign done   = (st == EN_WAIT) && !mem_busy;
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
   import tmr_store_pkg::*;
#(
   parameter bit HONOR_SUSPECT = 1'b1
) (
   input  logic [BYTE_W-1:0] c0,
   input  logic [BYTE_W-1:0] c1,
   input  logic [BYTE_W-1:0] c2,
   input  logic [NCOPY-1:0]  suspect,
   output vote_t             res
);
   logic e01, e02, e12;

   if (HONOR_SUSPECT) begin : g_suspect
      assign e01 = (c0 == c1) && !suspect[0] && !suspect[1];
      assign e02 = (c0 == c2) && !suspect[0] && !suspect[2];
      assign e12 = (c1 == c2) && !suspect[1] && !suspect[2];
   end else begin : g_plain
      logic [NCOPY-1:0] unused_suspect;
      assign unused_suspect = suspect;
      assign e01 = (c0 == c1);
      assign e02 = (c0 == c2);
      assign e12 = (c1 == c2);
   end

   always_comb begin
      res.value  = c0;
      res.single = 1'b0;
      res.total  = 1'b0;
      if (e01 && e02) begin
         res.value = c0;
      end else if (e01 || e02) begin
         res.single = 1'b1;
      end else if (e12) begin
         res.value  = c1;
         res.single = 1'b1;
      end else begin
         res.total = 1'b1;
      end
   end
endmodule

// File: rtl/tmr_byte_store.sv
module tmr_byte_store
   import tmr_store_pkg::*;
#(
   parameter int MEM_DEPTH = 256,
   parameter int ADDR_W    = 8,
   parameter bit READBACK  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic              host_ack,
   output logic [7:0]        host_rdata,
   output logic              host_single,
   output logic              host_total,
   output logic              host_exhausted,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              mem_we,
   output logic              mem_rd,
   input  logic              mem_busy
);
   localparam int NB_W = ADDR_W + 2;

   if (ADDR_W != $clog2(MEM_DEPTH)) begin : g_bad_addr_w
      $error("ADDR_W must equal clog2(MEM_DEPTH)");
   end
   if (ADDR_W > BYTE_W) begin : g_bad_ptr_w
      $error("pointer must fit in one stored byte");
   end
   if (MEM_DEPTH < 4) begin : g_bad_depth
      $error("memory too small for pointer plus one group");
   end

   seq_t                          st;
   logic                          is_wr;
   logic [1:0]                    idx;
   logic [ADDR_W-1:0]             base;
   logic [BYTE_W-1:0]             data_q;
   logic [NCOPY-1:0][BYTE_W-1:0]  cp;
   logic [NCOPY-1:0]              suspect;
   logic [NB_W-1:0]               nb_w;
   logic                          room;
   vote_t                         vote;

   logic              eng_start, eng_we, eng_idle, eng_done;
   logic [ADDR_W-1:0] eng_addr;
   logic [BYTE_W-1:0] eng_wdata;

   assign nb_w = {2'b00, base} + NB_W'(NCOPY);
   assign room = (nb_w + NB_W'(NCOPY - 1)) <= NB_W'(MEM_DEPTH - 1);

   always_comb begin
      eng_we    = 1'b0;
      eng_addr  = '0;
      eng_wdata = data_q;
      unique case (st)
         SQ_RD, SQ_RB: eng_addr = base + ADDR_W'(idx);
         SQ_WR: begin
            eng_we   = 1'b1;
            eng_addr = base + ADDR_W'(idx);
         end
         SQ_PWR: begin
            eng_we    = 1'b1;
            eng_wdata = BYTE_W'(base);
         end
         default: ;
      endcase
   end

   assign eng_start = eng_idle &&
                      (st inside {SQ_PTR, SQ_RD, SQ_WR, SQ_RB, SQ_PWR});

   tmr_mem_engine #(.ADDR_W(ADDR_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (eng_start),
      .op_we     (eng_we),
      .addr      (eng_addr),
      .wdata     (eng_wdata),
      .idle      (eng_idle),
      .done      (eng_done),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rd    (mem_rd),
      .mem_busy  (mem_busy)
   );

   tmr_voter #(.HONOR_SUSPECT(READBACK)) u_vote (
      .c0      (cp[0]),
      .c1      (cp[1]),
      .c2      (cp[2]),
      .suspect (suspect),
      .res     (vote)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st             <= SQ_IDLE;
         is_wr          <= 1'b0;
         idx            <= '0;
         base           <= '0;
         data_q         <= '0;
         cp             <= '0;
         suspect        <= '0;
         host_ack       <= 1'b0;
         host_rdata     <= '0;
         host_single    <= 1'b0;
         host_total     <= 1'b0;
         host_exhausted <= 1'b0;
      end else begin
         host_ack <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (host_wr) begin
                  is_wr  <= 1'b1;
                  data_q <= host_wdata;
                  st     <= SQ_PTR;
               end else if (host_rd) begin
                  is_wr <= 1'b0;
                  st    <= SQ_PTR;
               end
            end
            SQ_PTR: if (eng_done) begin
               base <= mem_rdata[ADDR_W-1:0];
               idx  <= '0;
               st   <= is_wr ? SQ_WR : SQ_RD;
            end
            SQ_RD: if (eng_done) begin
               cp[idx] <= mem_rdata;
               if (idx == 2'd2) st <= SQ_VOTE;
               else             idx <= idx + 2'd1;
            end
            SQ_VOTE: begin
               host_rdata  <= vote.value;
               host_single <= vote.single;
               host_total  <= vote.total;
               suspect     <= '0;
               st          <= SQ_DONE;
               if (vote.total) begin
                  if (room) begin
                     base   <= nb_w[ADDR_W-1:0];
                     data_q <= vote.value;
                     st     <= SQ_PWR;
                  end else begin
                     host_exhausted <= 1'b1;
                  end
               end
            end
            SQ_PWR: if (eng_done) begin
               idx <= '0;
               st  <= SQ_WR;
            end
            SQ_WR: if (eng_done) begin
               if (READBACK)          st  <= SQ_RB;
               else if (idx == 2'd2)  st  <= SQ_DONE;
               else                   idx <= idx + 2'd1;
            end
            SQ_RB: if (eng_done) begin
               suspect[idx] <= (mem_rdata != data_q);
               if (idx == 2'd2) begin
                  st <= SQ_DONE;
               end else begin
                  idx <= idx + 2'd1;
                  st  <= SQ_WR;
               end
            end
            SQ_DONE: begin
               host_ack <= 1'b1;
               st       <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tmr_byte_store_chk.sv
module tmr_byte_store_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_ack,
   input logic              host_single,
   input logic              host_total,
   input logic              host_exhausted,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              mem_rd,
   input logic              mem_busy
);
   assert_strobe_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_rd) |-> !mem_busy);

   assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_rd));

   assert_ack_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);

   assert_exhaust_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_exhausted |=> host_exhausted);

   assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_single && host_total));

   assert_ptr_write_on_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == '0) |-> (host_total && !host_exhausted));
endmodule

bind tmr_byte_store tmr_byte_store_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .host_ack       (host_ack),
   .host_single    (host_single),
   .host_total     (host_total),
   .host_exhausted (host_exhausted),
   .mem_addr       (mem_addr),
   .mem_we         (mem_we),
   .mem_rd         (mem_rd),
   .mem_busy       (mem_busy)
);

// File: tb/tb_tmr_byte_store.sv
`timescale 1ns/1ps
module tb_tmr_byte_store;
   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam int LAT   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_rd = 1'b0, host_wr = 1'b0;
   logic [7:0]    host_wdata = '0;
   logic          host_ack, host_single, host_total, host_exhausted;
   logic [7:0]    host_rdata;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata, mem_rdata;
   logic          mem_we, mem_rd, mem_busy;

   always #5 clk = ~clk;

   tmr_byte_store #(.MEM_DEPTH(DEPTH), .ADDR_W(AW), .READBACK(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
      .host_single(host_single), .host_total(host_total),
      .host_exhausted(host_exhausted), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
      .mem_rd(mem_rd), .mem_busy(mem_busy)
   );

   // memory model with write-flip fault injection and an access log
   logic [7:0] mem  [DEPTH];
   logic [7:0] flip [DEPTH];
   int         busy_cnt = 0;
   int         log_n = 0;
   logic [AW-1:0] log_a [64];
   logic          log_w [64];

   always @(posedge clk) begin
      if (mem_we || mem_rd) begin
         if (mem_we) mem[mem_addr] <= mem_wdata ^ flip[mem_addr];
         busy_cnt <= LAT;
         if (log_n < 64) begin
            log_a[log_n] <= mem_addr;
            log_w[log_n] <= mem_we;
            log_n <= log_n + 1;
         end
      end else if (busy_cnt > 0) begin
         busy_cnt <= busy_cnt - 1;
      end
   end
   assign mem_busy  = (busy_cnt != 0);
   assign mem_rdata = mem[mem_addr];

   int n_chk = 0, n_bad = 0;
   logic [2:0] susp_m = '0;
   logic       exh_m = 1'b0;
   logic [7:0] rd_m = '0;
   logic       sg_m = 1'b0, tt_m = 1'b0;
   int         acks_seen;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] vote_f(input logic [7:0] a, b, c, input logic [2:0] s);
      logic x01, x02, x12;
      x01 = (a == b) && !s[0] && !s[1];
      x02 = (a == c) && !s[0] && !s[2];
      x12 = (b == c) && !s[1] && !s[2];
      if (x01 && x02)      return {a, 2'b00};
      else if (x01 || x02) return {a, 2'b10};
      else if (x12)        return {b, 2'b10};
      else                 return {a, 2'b01};
   endfunction

   task automatic run_op(input logic wr, input logic rd, input logic [7:0] d,
                         input int intrude_at);
      int t;
      log_n = 0;
      acks_seen = 0;
      @(negedge clk);
      host_wr = wr; host_rd = rd; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      t = 0;
      while (host_ack !== 1'b1 && t < 2000) begin
         if (t == intrude_at) begin host_wr = 1'b1; host_wdata = ~d; end
         else begin host_wr = 1'b0; end
         @(negedge clk);
         t++;
      end
      host_wr = 1'b0;
      if (t >= 2000) chk("R9 watchdog ack", 0, 1);
      else acks_seen = 1;
   endtask

   // full read with model prediction and checks
   task automatic do_read(input string tag);
      int b, nb;
      logic [7:0] c0, c1, c2, pv;
      logic [9:0] v;
      logic reloc;
      b = int'(mem[0][AW-1:0]);
      c0 = mem[b]; c1 = mem[b+1]; c2 = mem[b+2];
      v = vote_f(c0, c1, c2, susp_m);
      pv = mem[0];
      reloc = 1'b0;
      nb = b + 3;
      if (v[0]) begin
         if (nb + 2 <= DEPTH - 1) reloc = 1'b1;
         else exh_m = 1'b1;
      end
      run_op(1'b0, 1'b1, 8'h00, -1);
      chk({tag, " R3/R4/R5 value"}, host_rdata, v[9:2]);
      chk({tag, " R4 single"}, host_single, v[1]);
      chk({tag, " R5 total"}, host_total, v[0]);
      chk({tag, " R7 exhausted"}, host_exhausted, exh_m);
      chk({tag, " R1 first access is pointer read"}, {log_w[0], 4'(log_a[0])}, 5'd0);
      if (reloc) begin
         chk({tag, " R6 access count"}, log_n, 4 + 1 + 6);
         chk({tag, " R6 pointer write order"}, {log_w[4], 4'(log_a[4])}, {1'b1, 4'd0});
         chk({tag, " R6 pointer value"}, mem[0], nb);
         for (int i = 0; i < 3; i++) begin
            chk({tag, " R6 copy moved"}, mem[nb+i], c0 ^ flip[nb+i]);
            susp_m[i] = (flip[nb+i] != 0);
         end
      end else begin
         chk({tag, " R7 no write on read"}, log_n, 4);
         chk({tag, " R7 pointer kept"}, mem[0], pv);
         susp_m = '0;
      end
      rd_m = v[9:2]; sg_m = v[1]; tt_m = v[0];
      @(negedge clk);
      chk({tag, " R9 ack one cycle"}, host_ack, 0);
   endtask

   task automatic do_write(input logic [7:0] d, input logic both);
      int b;
      b = int'(mem[0][AW-1:0]);
      run_op(1'b1, both, d, -1);
      chk("R2 access count", log_n, 7);
      chk("R1 pointer read first", {log_w[0], 4'(log_a[0])}, 5'd0);
      for (int i = 0; i < 3; i++) begin
         chk("R2 copy write order", {log_w[1+2*i], 4'(log_a[1+2*i])}, {1'b1, 4'(b+i)});
         chk("R2 readback order", {log_w[2+2*i], 4'(log_a[2+2*i])}, {1'b0, 4'(b+i)});
         chk("R2 copy value", mem[b+i], d ^ flip[b+i]);
         susp_m[i] = (flip[b+i] != 0);
      end
      chk("R9 write leaves read result", {host_rdata, host_single, host_total},
          {rd_m, sg_m, tt_m});
      @(negedge clk);
      chk("R9 ack one cycle", host_ack, 0);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL R9 global watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int b, q, k;
      logic [7:0] d;
      void'($urandom(32'd2417));
      for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; flip[i] = 8'h00; end
      mem[0] = 8'd1;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 ack", host_ack, 0);
      chk("R11 flags", {host_single, host_total, host_exhausted}, 0);
      chk("R11 strobes", {mem_we, mem_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      do_write(8'hA5, 1'b0);
      do_read("clean");
      // one outlier in each position
      for (int p = 0; p < 3; p++) begin
         b = int'(mem[0][AW-1:0]);
         mem[b+p] = mem[b+p] ^ 8'h40;
         do_read("single outlier");
         chk("R4 single flag", host_single, 1);
         do_write(8'hA5, 1'b0);
      end
      // total disagreement, relocation 1 -> 4
      b = int'(mem[0][AW-1:0]);
      mem[b] = 8'h11; mem[b+1] = 8'h22; mem[b+2] = 8'h33;
      do_read("total");
      chk("R6 new base", mem[0], 4);
      chk("R5 returns copy0", host_rdata, 8'h11);
      do_read("after move");
      chk("R3 clean after move", {host_single, host_total}, 0);

      // R8: suspect copy after bad read-back, then repaired in place
      b = int'(mem[0][AW-1:0]);
      flip[b+2] = 8'h10;
      do_write(8'h3C, 1'b0);
      flip[b+2] = 8'h00;
      mem[b+2] = 8'h3C;
      do_read("suspect");
      chk("R8 suspect counted", {host_rdata, host_single, host_total}, {8'h3C, 2'b10});

      // R9: both requests -> write wins
      do_write(8'h5A, 1'b1);

      // R9: intruding request during a read is ignored
      b = int'(mem[0][AW-1:0]);
      run_op(1'b0, 1'b1, 8'h77, 3);
      chk("R9 read result with intrusion", host_rdata, 8'h5A);
      chk("R9 intrusion no write", log_n, 4);
      q = 0;
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         if (host_ack || mem_we || mem_rd) q++;
      end
      chk("R9 quiet after ignored request", q, 0);
      chk("R9 copies untouched", {mem[b], mem[b+1], mem[b+2]}, {3{8'h5A}});
      rd_m = 8'h5A; sg_m = 1'b0; tt_m = 1'b0;

      // random mix before exhaustion (no total disagreement)
      for (int it = 0; it < 25; it++) begin
         k = int'($urandom % 3);
         d = 8'($urandom);
         if (k == 0) do_write(d, 1'b0);
         else begin
            b = int'(mem[0][AW-1:0]);
            if (k == 2) begin
               q = int'($urandom % 3);
               mem[b+q] = mem[b+q] ^ 8'(1 + ($urandom % 255));
            end
            do_read("random");
         end
      end

      // walk groups until exhaustion
      for (int g = 0; g < 5; g++) begin
         b = int'(mem[0][AW-1:0]);
         mem[b] = 8'hC0 + 8'(g); mem[b+1] = 8'h01; mem[b+2] = 8'h02;
         do_read("exhaust walk");
      end
      chk("R7 exhausted reached", host_exhausted, 1);
      chk("R7 last group kept", mem[0], 13);

      // random mix after exhaustion, including total disagreement
      for (int it = 0; it < 20; it++) begin
         k = int'($urandom % 3);
         d = 8'($urandom);
         if (k == 0) do_write(d, 1'b0);
         else begin
            b = int'(mem[0][AW-1:0]);
            for (int i = 0; i < 3; i++)
               if ($urandom % 2 == 1) mem[b+i] = 8'($urandom);
            do_read("random exhausted");
         end
      end
      chk("R7 sticky", host_exhausted, 1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule